// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Sequencer

This block executes one programmed-I/O transfer at a time on a parallel ATA bus. A host presents a request carrying a combined address/select field, a 16-bit write value, a direction flag and a flag that picks the register timing set or the data-port timing set. The block then walks the bus through three phases:

- an address setup phase with both strobes inactive;
- an active phase with the read or write strobe asserted;
- a recovery phase.

When the recovery phase ends, the block returns read data and raises a one-cycle completion pulse.

All phase lengths are counts of the block clock, taken from configuration inputs. The ready line from the device passes through a two-flop synchronizer. When ready checking is enabled, that line can lengthen the active phase, but only up to a programmable limit. A limit overrun sets a sticky flag and does not abort the transfer. Recovery makes up whatever remains of the programmed cycle time, and is never shorter than the programmed minimum recovery. On writes, the data bus stays driven for a mode-dependent number of clocks after the strobe is released.

Top module: `ata_pio_seq`

## Requirements
- R1: Out of reset and whenever `busy` is low, `cs0_n`, `cs1_n`, `dior_n` and `diow_n` are all high, `dd_oe` is low and `iordy_timeout` is low after reset.
- R2: The 5-bit `req_sel` field maps bit 4..2 to `da[2:0]`, bit 1 to `cs1_n` and bit 0 to `cs0_n`. These levels are driven unchanged from the first busy cycle through the last recovery cycle.
- R3: The setup phase lasts max(`cfg_setup`,1) cycles. In it the select lines are driven and both strobes are high. Both timing sets share this one setup value.
- R4: With ready checking off, the strobe stays low for max(act,1) cycles. When `req_reg`=1 the value act comes from `cfg_act_reg`; when `req_reg`=0 it comes from `cfg_act_dat`. `dior_n` is used for reads (`req_write`=0) and `diow_n` for writes.
- R5: With `cfg_iordy_en`=1, the synchronized ready level is ignored during the first `cfg_iordy_skip` active cycles. The active phase ends at the first cycle that meets both of these conditions:
  - at least max(act,1) cycles have elapsed;
  - the synchronized ready level is high, or `cfg_iordy_limit` active cycles have elapsed.
- R6: An active phase that ends with ready checking on but without ready seen sets `iordy_timeout`. The flag stays set until reset, and the transfer still completes with normal recovery.
- R7: Let E be the actual active length, cyc the selected cycle time and rec the selected minimum recovery. Recovery lasts (cyc−E) cycles if cyc>E and cyc−E>rec; otherwise it lasts rec cycles. Recovery is never shorter than 1 cycle.
- R8: On a write, `dd_out` carries the request data with `dd_oe` high for the whole active phase, and for the first W recovery cycles. W is 3 for `cfg_pio_mode`=0, 2 for modes 1 and 2, and 1 for modes 3 and 4. A write's recovery lasts at least W cycles. On a read, `dd_oe` never goes high.
- R9: A read returns in `rd_data` the `dd_in` value present in the last active cycle, i.e. at the rising edge of `dior_n`. `rd_data` changes at no other time.
- R10: A request is accepted only when `busy` is low. `busy` is high from the cycle after acceptance until the last recovery cycle. `done` is high for exactly one cycle, which is the first cycle with `busy` low. Requests presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 1 | 1 = register timing set, 0 = data-port timing set |
| req_sel | input | 5 | {A2,A1,A0,CS1 level,CS0 level} |
| req_wdata | input | 16 | Write value |
| cfg_setup | input | CW | Setup cycles (shared) |
| cfg_act_reg | input | CW | Register active cycles |
| cfg_cyc_reg | input | CW | Register total cycle time |
| cfg_rec_reg | input | CW | Register minimum recovery |
| cfg_act_dat | input | CW | Data active cycles |
| cfg_cyc_dat | input | CW | Data total cycle time |
| cfg_rec_dat | input | CW | Data minimum recovery |
| cfg_iordy_en | input | 1 | Enable ready stretching |
| cfg_iordy_skip | input | CW | Active cycles before ready is looked at |
| cfg_iordy_limit | input | CW | Active-cycle bound for the ready wait |
| cfg_pio_mode | input | 3 | PIO mode 0..4, sets write hold |
| iordy | input | 1 | Device ready line (asynchronous) |
| dd_in | input | 16 | Data bus input |
| cs0_n | output | 1 | Chip select 0, active low |
| cs1_n | output | 1 | Chip select 1, active low |
| da | output | 3 | Device address |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Data bus output value |
| dd_oe | output | 1 | Data bus output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read value |
| iordy_timeout | output | 1 | Sticky ready-wait overrun |

## Verification
The bench goes after the boundaries where an off-by-one hides:

- **Zero timing values.** A design that failed to clamp them would produce a zero-length setup or strobe.
- **Recovery where cyc−E equals rec.** A strict versus non-strict comparison gives a recovery one cycle different.
- **Timing-set selection.** The data set is programmed one cycle longer than the register set, so a swapped mux shows as a wrong strobe width.
- **Ready rising mid-strobe.** This exposes a wrong synchronizer depth or skip window as a shifted strobe end.
- **Ready that never comes.** A design that aborts or hangs instead of flagging the overrun is caught here.
- **Write hold longer than recovery.** A design that released the bus early, or ended recovery while still driving, is caught.
- **Read data changing every strobe cycle.** Capturing on the wrong edge returns a neighbouring value.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [2:0] da;
        logic       cs1_n;
        logic       cs0_n;
    } bus_sel_t;

    localparam bus_sel_t SEL_IDLE = '{da: 3'd0, cs1_n: 1'b1, cs0_n: 1'b1};

    typedef struct packed {
        logic              write;
        logic              reg_sel;
        bus_sel_t          sel;
        logic [DATA_W-1:0] data;
    } pio_req_t;

    // Clocks the write value stays on the bus after the strobe rises.
    function automatic logic [1:0] write_hold(input logic [2:0] mode);
        if (mode == 3'd0)
            return 2'd3;
        else if (mode < 3'd3)
            return 2'd2;
        else
            return 2'd1;
    endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pio_timing_sel.sv
module pio_timing_sel #(
    parameter int CW = 8
) (
    input  logic          reg_sel,
    input  logic [CW-1:0] setup,
    input  logic [CW-1:0] act_reg,
    input  logic [CW-1:0] cyc_reg,
    input  logic [CW-1:0] rec_reg,
    input  logic [CW-1:0] act_dat,
    input  logic [CW-1:0] cyc_dat,
    input  logic [CW-1:0] rec_dat,
    output logic [CW-1:0] setup_len,
    output logic [CW-1:0] act_len,
    output logic [CW-1:0] cyc_len,
    output logic [CW-1:0] rec_min
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] act_raw;

    always_comb begin
        act_raw   = reg_sel ? act_reg : act_dat;
        cyc_len   = reg_sel ? cyc_reg : cyc_dat;
        rec_min   = reg_sel ? rec_reg : rec_dat;
        setup_len = (setup == '0) ? ONE : setup;
        act_len   = (act_raw == '0) ? ONE : act_raw;
    end
endmodule

// File: rtl/pio_recovery_calc.sv
module pio_recovery_calc #(
    parameter int CW   = 8,
    parameter int CNTW = CW + 1
) (
    input  logic [CNTW-1:0] eff_act,
    input  logic [CW-1:0]   cyc_len,
    input  logic [CW-1:0]   rec_min,
    input  logic [1:0]      hold,
    input  logic            is_write,
    output logic [CNTW-1:0] rec_len
);
    logic [CNTW-1:0] cyc_x, rec_x, hold_x, diff, base;

    always_comb begin
        cyc_x  = {{(CNTW-CW){1'b0}}, cyc_len};
        rec_x  = {{(CNTW-CW){1'b0}}, rec_min};
        hold_x = {{(CNTW-2){1'b0}}, hold};
        diff   = cyc_x - eff_act;
        base   = ((cyc_x > eff_act) && (diff > rec_x)) ? diff : rec_x;
        if (base == '0)
            base = CNTW'(1);
        if (is_write && (hold_x > base))
            base = hold_x;
        rec_len = base;
    end
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int CW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_reg,
    input  logic [4:0]        req_sel,
    input  logic [15:0]       req_wdata,
    input  logic [CW-1:0]     cfg_setup,
    input  logic [CW-1:0]     cfg_act_reg,
    input  logic [CW-1:0]     cfg_cyc_reg,
    input  logic [CW-1:0]     cfg_rec_reg,
    input  logic [CW-1:0]     cfg_act_dat,
    input  logic [CW-1:0]     cfg_cyc_dat,
    input  logic [CW-1:0]     cfg_rec_dat,
    input  logic              cfg_iordy_en,
    input  logic [CW-1:0]     cfg_iordy_skip,
    input  logic [CW-1:0]     cfg_iordy_limit,
    input  logic [2:0]        cfg_pio_mode,
    input  logic              iordy,
    input  logic [15:0]       dd_in,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic [2:0]        da,
    output logic              dior_n,
    output logic              diow_n,
    output logic [15:0]       dd_out,
    output logic              dd_oe,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rd_data,
    output logic              iordy_timeout
);
    localparam int CNTW = CW + 1;

    phase_e          ph;
    pio_req_t        cur;
    logic [CNTW-1:0] cnt, elapsed, rec_len_q, rec_len_d;
    logic [CW-1:0]   setup_len, act_len, cyc_len, rec_min;
    logic [1:0]      hold;
    logic            iordy_s, ready_seen, act_end;

    pio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (iordy),
        .q   (iordy_s)
    );

    pio_timing_sel #(.CW(CW)) u_tsel (
        .reg_sel   (cur.reg_sel),
        .setup     (cfg_setup),
        .act_reg   (cfg_act_reg),
        .cyc_reg   (cfg_cyc_reg),
        .rec_reg   (cfg_rec_reg),
        .act_dat   (cfg_act_dat),
        .cyc_dat   (cfg_cyc_dat),
        .rec_dat   (cfg_rec_dat),
        .setup_len (setup_len),
        .act_len   (act_len),
        .cyc_len   (cyc_len),
        .rec_min   (rec_min)
    );

    assign hold    = write_hold(cfg_pio_mode);
    assign elapsed = cnt + CNTW'(1);

    pio_recovery_calc #(.CW(CW), .CNTW(CNTW)) u_rcalc (
        .eff_act  (elapsed),
        .cyc_len  (cyc_len),
        .rec_min  (rec_min),
        .hold     (hold),
        .is_write (cur.write),
        .rec_len  (rec_len_d)
    );

    // Active-phase end decision
    always_comb begin
        ready_seen = iordy_s && (cnt >= {1'b0, cfg_iordy_skip});
        act_end    = (elapsed >= {1'b0, act_len}) &&
                     (!cfg_iordy_en || ready_seen ||
                      (elapsed >= {1'b0, cfg_iordy_limit}));
    end

    // Phase sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            ph            <= PH_IDLE;
            cnt           <= '0;
            cur           <= '0;
            rec_len_q     <= '0;
            rd_data       <= '0;
            done          <= 1'b0;
            iordy_timeout <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur.write   <= req_write;
                        cur.reg_sel <= req_reg;
                        cur.sel     <= bus_sel_t'(req_sel);
                        cur.data    <= req_wdata;
                        cnt         <= '0;
                        ph          <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (elapsed >= {1'b0, setup_len}) begin
                        cnt <= '0;
                        ph  <= PH_ACTIVE;
                    end else begin
                        cnt <= elapsed;
                    end
                end
                PH_ACTIVE: begin
                    if (act_end) begin
                        cnt       <= '0;
                        rec_len_q <= rec_len_d;
                        ph        <= PH_RECOV;
                        if (!cur.write)
                            rd_data <= dd_in;
                        if (cfg_iordy_en && !ready_seen)
                            iordy_timeout <= 1'b1;
                    end else begin
                        cnt <= elapsed;
                    end
                end
                PH_RECOV: begin
                    if (elapsed >= rec_len_q) begin
                        cnt  <= '0;
                        ph   <= PH_IDLE;
                        done <= 1'b1;
                    end else begin
                        cnt <= elapsed;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Bus drive
    bus_sel_t sel_out;
    always_comb begin
        sel_out = (ph == PH_IDLE) ? SEL_IDLE : cur.sel;
        da      = sel_out.da;
        cs1_n   = sel_out.cs1_n;
        cs0_n   = sel_out.cs0_n;
        dior_n  = !((ph == PH_ACTIVE) && !cur.write);
        diow_n  = !((ph == PH_ACTIVE) &&  cur.write);
        dd_oe   = cur.write && ((ph == PH_ACTIVE) ||
                  ((ph == PH_RECOV) && (cnt < {{(CNTW-2){1'b0}}, hold})));
        dd_out  = cur.data;
        busy    = (ph != PH_IDLE);
    end

    // Assertions
    a_r1_idle_levels: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs0_n && cs1_n && dior_n && diow_n && !dd_oe));

    a_r2_sel_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable({da, cs1_n, cs0_n}));

    a_r8_no_contention: assert property (@(posedge clk) disable iff (rst)
        (dior_n || diow_n) && (!dd_oe || dior_n));

    a_r9_capture_at_release: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_data) |-> ($past(!dior_n) && dior_n));

    a_r6_timeout_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(iordy_timeout) |-> iordy_timeout);

    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r7_recovery_nonzero: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_RECOV) |-> (rec_len_q != '0));

endmodule

// File: tb/sim_ata_pio_seq.sv
module sim_ata_pio_seq;
    localparam int CLK_P = 10;
    localparam int CW    = 8;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic rst, req_valid, req_write, req_reg, cfg_iordy_en, iordy;
    logic [4:0]  req_sel;
    logic [15:0] req_wdata, dd_in;
    logic [CW-1:0] cfg_setup, cfg_act_reg, cfg_cyc_reg, cfg_rec_reg;
    logic [CW-1:0] cfg_act_dat, cfg_cyc_dat, cfg_rec_dat;
    logic [CW-1:0] cfg_iordy_skip, cfg_iordy_limit;
    logic [2:0] cfg_pio_mode;
    logic cs0_n, cs1_n, dior_n, diow_n, dd_oe, busy, done, iordy_timeout;
    logic [2:0] da;
    logic [15:0] dd_out, rd_data;

    ata_pio_seq #(.CW(CW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_reg(req_reg), .req_sel(req_sel), .req_wdata(req_wdata),
        .cfg_setup(cfg_setup), .cfg_act_reg(cfg_act_reg), .cfg_cyc_reg(cfg_cyc_reg),
        .cfg_rec_reg(cfg_rec_reg), .cfg_act_dat(cfg_act_dat), .cfg_cyc_dat(cfg_cyc_dat),
        .cfg_rec_dat(cfg_rec_dat), .cfg_iordy_en(cfg_iordy_en),
        .cfg_iordy_skip(cfg_iordy_skip), .cfg_iordy_limit(cfg_iordy_limit),
        .cfg_pio_mode(cfg_pio_mode), .iordy(iordy), .dd_in(dd_in),
        .cs0_n(cs0_n), .cs1_n(cs1_n), .da(da), .dior_n(dior_n), .diow_n(diow_n),
        .dd_out(dd_out), .dd_oe(dd_oe), .busy(busy), .done(done),
        .rd_data(rd_data), .iordy_timeout(iordy_timeout)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit exp_tmo = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // imode: 0 ready held high, 1 ready never, 2 ready rises during active cycle rise_at+1
    task automatic run_cycle(input bit w, input bit rg, input logic [4:0] sel,
                             input logic [15:0] wd, input int imode, input int rise_at,
                             input bit poke);
        int t1, t2, t0, ti, sk, lim, S, E, R, th, wh, s_c, a_c, r_c, oe_c;
        bit got_done, tmo_now, poked;
        logic [15:0] base;
        t1 = int'(cfg_setup);
        t2 = rg ? int'(cfg_act_reg) : int'(cfg_act_dat);
        t0 = rg ? int'(cfg_cyc_reg) : int'(cfg_cyc_dat);
        ti = rg ? int'(cfg_rec_reg) : int'(cfg_rec_dat);
        sk = int'(cfg_iordy_skip);
        lim = int'(cfg_iordy_limit);
        S = imax(t1, 1);
        t2 = imax(t2, 1);
        if (imode == 0) th = sk + 1;
        else if (imode == 1) th = 100000;
        else th = imax(rise_at + 3, sk + 1);
        if (!cfg_iordy_en) begin
            E = t2; tmo_now = 1'b0;
        end else begin
            E = imax(t2, imin(th, lim));
            tmo_now = (E < th);
        end
        R = (t0 > E && (t0 - E) > ti) ? (t0 - E) : ti;
        R = imax(R, 1);
        if (cfg_pio_mode == 3'd0) wh = 3;
        else if (cfg_pio_mode < 3'd3) wh = 2;
        else wh = 1;
        if (w) R = imax(R, wh);
        base = wd ^ 16'h5A3C;

        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_reg = rg; req_sel = sel; req_wdata = wd;
        iordy = (imode == 0);
        dd_in = base;
        @(negedge clk);
        req_valid = 1'b0;
        req_sel = ~sel;
        chk("R10 busy after accept", busy, 1);
        s_c = 0; a_c = 0; r_c = 0; oe_c = 0; got_done = 1'b0; poked = 1'b0;
        for (int k = 0; k < 600; k++) begin
            if (poked) begin req_valid = 1'b0; poked = 1'b0; end
            if (done) begin
                got_done = 1'b1;
                chk("R10 busy low at done", busy, 0);
                break;
            end
            if (!dior_n || !diow_n) begin
                a_c++;
                chk("R2 select during strobe", {da, cs1_n, cs0_n}, sel);
                chk("R4 strobe direction", w ? int'(dior_n) : int'(diow_n), 1);
                if (w) begin
                    chk("R8 write data on bus", dd_out, wd);
                    chk("R8 oe during write strobe", dd_oe, 1);
                end else begin
                    chk("R8 no oe on read", dd_oe, 0);
                    dd_in = base + 16'(a_c);
                end
                if (imode == 2 && a_c == rise_at + 1) iordy = 1'b1;
                if (poke && a_c == 1) begin
                    req_valid = 1'b1; req_sel = 5'b10110; poked = 1'b1;
                end
            end else if (busy && a_c == 0) begin
                s_c++;
                chk("R2 select during setup", {da, cs1_n, cs0_n}, sel);
            end else if (busy) begin
                r_c++;
                chk("R2 select during recovery", {da, cs1_n, cs0_n}, sel);
                if (dd_oe) oe_c++;
            end
            @(negedge clk);
        end
        chk("R10 done seen", got_done, 1);
        chk("R3 setup cycles", s_c, S);
        chk(rg ? "R4 active cycles reg set" : "R4 active cycles data set", a_c, E);
        if (cfg_iordy_en) chk("R5 ready-stretched active", a_c, E);
        chk("R7 recovery cycles", r_c, R);
        chk("R8 write hold after strobe", oe_c, w ? wh : 0);
        if (!w) chk("R9 read capture at strobe release", rd_data, base + 16'(E));
        exp_tmo = exp_tmo | tmo_now;
        chk("R6 sticky timeout", iordy_timeout, exp_tmo);
        @(negedge clk);
        chk("R10 done single pulse", done, 0);
        chk("R10 no second transfer", busy, 0);
        chk("R1 idle levels", {cs0_n, cs1_n, dior_n, diow_n, dd_oe}, 5'b11110);
    endtask

    initial begin
        #(CLK_P * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_reg = 1'b0;
        req_sel = 5'b00011; req_wdata = '0; dd_in = '0; iordy = 1'b1;
        cfg_setup = 8'd1; cfg_act_reg = 8'd2; cfg_cyc_reg = 8'd6; cfg_rec_reg = 8'd1;
        cfg_act_dat = 8'd3; cfg_cyc_dat = 8'd7; cfg_rec_dat = 8'd2;
        cfg_iordy_en = 1'b0; cfg_iordy_skip = 8'd0; cfg_iordy_limit = 8'd0;
        cfg_pio_mode = 3'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset cs0_n", cs0_n, 1);
        chk("R1 reset cs1_n", cs1_n, 1);
        chk("R1 reset strobes", {dior_n, diow_n}, 2'b11);
        chk("R1 reset oe/busy/done", {dd_oe, busy, done, iordy_timeout}, 4'b0000);

        // Directed: command-block and alternate-status selects, ignore while busy
        run_cycle(1'b0, 1'b1, 5'b11110, 16'h1234, 0, 0, 1'b0);
        run_cycle(1'b1, 1'b1, 5'b11001, 16'hBEEF, 0, 0, 1'b1);
        run_cycle(1'b0, 1'b0, 5'b00010, 16'h0F0F, 0, 0, 1'b1);

        // Directed: ready rises mid-strobe
        cfg_iordy_en = 1'b1; cfg_iordy_skip = 8'd2; cfg_iordy_limit = 8'd20;
        cfg_act_reg = 8'd1;
        run_cycle(1'b0, 1'b1, 5'b00110, 16'h4444, 2, 3, 1'b0);
        chk("R6 no timeout when ready arrives", iordy_timeout, 0);
        cfg_iordy_en = 1'b0;

        // Sweep: timing sets, zero clamps, recovery comparison, write hold by mode
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 9; c++)
                    for (int d = 0; d < 3; d++)
                        for (int m = 0; m < 4; m++) begin
                            cfg_setup   = 8'(a);
                            cfg_act_reg = 8'(b);     cfg_cyc_reg = 8'(c);     cfg_rec_reg = 8'(d);
                            cfg_act_dat = 8'(b + 1); cfg_cyc_dat = 8'(c + 2); cfg_rec_dat = 8'(d + 1);
                            cfg_pio_mode = 3'((a + b + c + d + m) % 5);
                            run_cycle(m[0], m[1], {3'(c), 2'b10}, 16'(a * 4096 + c * 16 + m), 0, 0, 1'b0);
                        end

        // Sweep: ready stretching and timeout
        cfg_iordy_en = 1'b1; cfg_setup = 8'd1;
        for (int s = 0; s < 4; s++)
            for (int l = 0; l < 10; l++)
                for (int t = 1; t < 4; t++)
                    for (int md = 0; md < 2; md++) begin
                        cfg_iordy_skip = 8'(s); cfg_iordy_limit = 8'(l);
                        cfg_act_reg = 8'(t); cfg_act_dat = 8'(t + 1);
                        cfg_cyc_reg = 8'd6; cfg_rec_reg = 8'd1;
                        cfg_pio_mode = 3'((s + l) % 5);
                        run_cycle(l[0], t[0], 5'b01110, 16'(s * 256 + l * 8 + t), md, 0, 1'b0);
                    end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule